// File: doc/BRIEF.md
# CCD Converter Offset and Fine-Gain Calibration Sequencer

This block trims a 14-bit CCD image converter without software taking part in the loop. It drives two signed trim-DAC codes, one for black-level offset and one for fine gain. It watches the converter's straight-binary output words and moves each code until the output dithers at its target level. The offset trim always runs first and uses a dark input. Its target is reached when the output toggles between codes 0 and 1. The gain trim runs second and uses a saturated input. Its target is reached when the output toggles between 0x3FFE and 0x3FFF. Keeping this order stops the two adjustments from disturbing each other.

A host pulses `start` and then waits for `await_ack`. The `phase_gain` output tells the host which illumination to apply: low means dark, high means saturated. Once the illumination is in place, the host pulses `phase_ack`. For each trim, the block runs a 10-step successive-approximation search over the signed DAC code. After the search it makes one-code linear refinement steps. Each decision rests on a window of averaged samples. If the trim cannot converge, the block stops and raises `err`.

Top module: `ccd_trim_cal`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `await_ack` are low, and both DAC codes are 0.
- R2: A `start` pulse while idle sets `busy` and `await_ack` with `phase_gain` low, and sets both codes to 0. The codes then stay at 0 until `phase_ack` is seen.
- R3: The DAC codes are 10-bit two's complement values from -512 to 511, and a larger code raises the converter output. The offset trim finishes at a code where a dark input produces both codes 0 and 1 within one window.
- R4: The gain phase begins only after the offset trim has converged. At that point `await_ack` is high with `phase_gain` high. The gain code stays 0 through the whole offset phase, and the offset code does not change during the gain phase.
- R5: The gain trim finishes at a code where a saturated input produces both 0x3FFE and 0x3FFF within one window. When it does, `done` goes high and `busy` goes low.
- R6: Each window first discards DISCARD valid samples and then sums 2^LOG2_AVG valid samples. Words presented while `smp_valid` is low are ignored. An out-of-range word with bit 13 set counts as 16384, and one with bit 13 clear counts as -1. The trial is too high when the mean exceeds the target minus one half.
- R7: If refinement needs to step past code -512 or 511, the block sets `err`, leaves `done` low, drops `busy`, and does not start the gain phase.
- R8: If REFINE_MAX refinement windows pass without convergence, the block sets `err` and drops `busy`.
- R9: A `start` pulse is ignored while `busy` is high. A new `start` clears `done` and `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a calibration run (pulse) |
| phase_ack | input | 1 | Host confirms the illumination for the current phase |
| smp_valid | input | 1 | Converter data word strobe |
| smp_code | input | 14 | Converter output word, straight binary |
| smp_oor | input | 1 | Converter out-of-range flag for this word |
| ofs_code | output | 10 | Signed offset trim-DAC code |
| gain_code | output | 10 | Signed fine-gain trim-DAC code |
| busy | output | 1 | Calibration run in progress |
| done | output | 1 | Last run finished with both trims converged |
| err | output | 1 | Last run stopped without convergence |
| await_ack | output | 1 | Waiting for `phase_ack` |
| phase_gain | output | 1 | Current phase: 0 offset (dark), 1 gain (saturated) |

## Verification
The hardest case to reach from the ports is the refinement bound. In that case the successive-approximation search ends next to the target, but no single DAC code produces the dithering pair. The bench reaches it with a converter model that moves two output codes per DAC step and has an odd dark level. As a result, refinement swings between codes that give -1/0 and 1/2 until the bound trips. The DAC-limit errors are reached by dark levels beyond both ends of the code range. The ignored-strobe rule is exercised by driving out-of-range junk words between valid strobes all the time.

// File: rtl/ccd_trim_pkg.sv
`timescale 1ns/1ps
package ccd_trim_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACK  = 2'd1,
        ST_MEAS = 2'd2
    } cal_state_t;

    typedef enum logic {
        PH_OFFSET = 1'b0,
        PH_GAIN   = 1'b1
    } cal_phase_t;

    // Outcome of one averaged measurement window
    typedef struct packed {
        logic fin;       // one-cycle pulse, window complete
        logic too_high;  // mean above target - 1/2
        logic conv;      // target and target-1 both seen
    } win_res_t;

    // Outcome of a search step (valid together with the step)
    typedef struct packed {
        logic ok;
        logic fail;
    } srch_res_t;

endpackage

// File: rtl/ccd_trim_window.sv
`timescale 1ns/1ps
module ccd_trim_window
    import ccd_trim_pkg::*;
#(
    parameter int CODE_W   = 14,
    parameter int LOG2_AVG = 3,
    parameter int DISCARD  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic              phase_gain,
    input  logic              smp_valid,
    input  logic [CODE_W-1:0] smp_code,
    input  logic              smp_oor,
    output win_res_t          res
);
    localparam int NSMP = 1 << LOG2_AVG;
    localparam int VW   = CODE_W + 2;
    localparam int SW   = VW + LOG2_AVG + 2;
    localparam int DW   = $clog2(DISCARD + 2);
    localparam int CW   = LOG2_AVG + 1;

    logic               active;
    logic [DW-1:0]      disc;
    logic [CW-1:0]      cnt;
    logic signed [SW-1:0] sum;
    logic               seen_t, seen_m, fin_q;

    logic signed [VW-1:0] val;
    logic [CODE_W-1:0]  tgt, tgt_m1;
    logic [SW-1:0]      thr_u;
    logic signed [SW-1:0] sum2;

    // Sample value: out-of-range words land just outside the code span
    always_comb begin
        if (!smp_oor)                  val = {2'b00, smp_code};
        else if (smp_code[CODE_W-1])   val = {2'b01, {CODE_W{1'b0}}};
        else                           val = '1;
    end

    always_comb begin
        tgt    = phase_gain ? '1 : CODE_W'(1);
        tgt_m1 = tgt - CODE_W'(1);
        thr_u  = ({{(SW-CODE_W){1'b0}}, tgt} << 1) - SW'(1);
        thr_u  = thr_u << LOG2_AVG;
        sum2   = sum <<< 1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            disc   <= '0;
            cnt    <= '0;
            sum    <= '0;
            seen_t <= 1'b0;
            seen_m <= 1'b0;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (arm) begin
                active <= 1'b1;
                disc   <= '0;
                cnt    <= '0;
                sum    <= '0;
                seen_t <= 1'b0;
                seen_m <= 1'b0;
            end else if (active && smp_valid) begin
                if (disc < DW'(DISCARD)) begin
                    disc <= disc + DW'(1);
                end else begin
                    sum    <= sum + SW'(val);
                    seen_t <= seen_t | (!smp_oor && smp_code == tgt);
                    seen_m <= seen_m | (!smp_oor && smp_code == tgt_m1);
                    cnt    <= cnt + CW'(1);
                    if (cnt == CW'(NSMP - 1)) begin
                        active <= 1'b0;
                        fin_q  <= 1'b1;
                    end
                end
            end
        end
    end

    always_comb begin
        res.fin      = fin_q;
        res.too_high = sum2 > $signed(thr_u);
        res.conv     = seen_t & seen_m;
    end

endmodule

// File: rtl/ccd_trim_search.sv
`timescale 1ns/1ps
module ccd_trim_search
    import ccd_trim_pkg::*;
#(
    parameter int DAC_W      = 10,
    parameter int REFINE_MAX = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic             step,
    input  logic             too_high,
    input  logic             conv,
    output logic [DAC_W-1:0] code_u,
    output srch_res_t        res
);
    localparam int IW = $clog2(DAC_W);
    localparam int RW = $clog2(REFINE_MAX + 1);

    logic [DAC_W-1:0] cur, trial;
    logic [IW-1:0]    idx;
    logic             refine;
    logic [RW-1:0]    rcnt;
    logic             at_lo, at_hi, cap;

    always_comb begin
        trial  = cur | (DAC_W'(1) << idx);
        code_u = refine ? cur : trial;
        at_lo  = (cur == '0);
        at_hi  = (cur == '1);
        cap    = (rcnt == RW'(REFINE_MAX - 1));
        res.ok   = step & refine & conv;
        res.fail = step & refine & !conv &
                   ((too_high & at_lo) | (!too_high & at_hi) | cap);
    end

    always_ff @(posedge clk) begin
        if (rst || init) begin
            cur    <= '0;
            idx    <= IW'(DAC_W - 1);
            refine <= 1'b0;
            rcnt   <= '0;
        end else if (step) begin
            if (!refine) begin
                if (!too_high) cur <= trial;
                if (idx == '0) refine <= 1'b1;
                else           idx    <= idx - IW'(1);
            end else if (!conv) begin
                if (too_high && !at_lo)       cur <= cur - DAC_W'(1);
                else if (!too_high && !at_hi) cur <= cur + DAC_W'(1);
                rcnt <= rcnt + RW'(1);
            end
        end
    end

endmodule

// File: rtl/ccd_trim_cal.sv
`timescale 1ns/1ps
module ccd_trim_cal
    import ccd_trim_pkg::*;
#(
    parameter int CODE_W     = 14,
    parameter int DAC_W      = 10,
    parameter int LOG2_AVG   = 3,
    parameter int DISCARD    = 2,
    parameter int REFINE_MAX = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    phase_ack,
    input  logic                    smp_valid,
    input  logic [CODE_W-1:0]       smp_code,
    input  logic                    smp_oor,
    output logic signed [DAC_W-1:0] ofs_code,
    output logic signed [DAC_W-1:0] gain_code,
    output logic                    busy,
    output logic                    done,
    output logic                    err,
    output logic                    await_ack,
    output logic                    phase_gain
);
    cal_state_t state;
    cal_phase_t phase;
    win_res_t   wres;
    srch_res_t  sres [2];
    srch_res_t  cur_res;
    logic [DAC_W-1:0] code_u [2];
    logic start_go, meas_fin, arm, ph_g;

    always_comb begin
        ph_g     = (phase == PH_GAIN);
        start_go = (state == ST_IDLE) && start;
        meas_fin = (state == ST_MEAS) && wres.fin;
        cur_res  = ph_g ? sres[1] : sres[0];
        arm      = ((state == ST_ACK) && phase_ack) ||
                   (meas_fin && !cur_res.ok && !cur_res.fail);
    end

    ccd_trim_window #(
        .CODE_W(CODE_W), .LOG2_AVG(LOG2_AVG), .DISCARD(DISCARD)
    ) u_win (
        .clk(clk), .rst(rst), .arm(arm), .phase_gain(ph_g),
        .smp_valid(smp_valid), .smp_code(smp_code), .smp_oor(smp_oor),
        .res(wres)
    );

    // One search engine per trim: index 0 offset, index 1 gain
    for (genvar g = 0; g < 2; g++) begin : g_trim
        logic step_g;
        assign step_g = meas_fin && (ph_g == (g == 1));
        ccd_trim_search #(
            .DAC_W(DAC_W), .REFINE_MAX(REFINE_MAX)
        ) u_srch (
            .clk(clk), .rst(rst), .init(start_go), .step(step_g),
            .too_high(wres.too_high), .conv(wres.conv),
            .code_u(code_u[g]), .res(sres[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            phase <= PH_OFFSET;
            done  <= 1'b0;
            err   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    phase <= PH_OFFSET;
                    done  <= 1'b0;
                    err   <= 1'b0;
                    state <= ST_ACK;
                end
                ST_ACK: if (phase_ack) state <= ST_MEAS;
                ST_MEAS: if (wres.fin) begin
                    if (cur_res.fail) begin
                        err   <= 1'b1;
                        state <= ST_IDLE;
                    end else if (cur_res.ok) begin
                        if (!ph_g) begin
                            phase <= PH_GAIN;
                            state <= ST_ACK;
                        end else begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Offset-binary search value to two's complement DAC code
    assign ofs_code   = $signed({~code_u[0][DAC_W-1], code_u[0][DAC_W-2:0]});
    assign gain_code  = $signed({~code_u[1][DAC_W-1], code_u[1][DAC_W-2:0]});
    assign busy       = (state != ST_IDLE);
    assign await_ack  = (state == ST_ACK);
    assign phase_gain = ph_g;

endmodule

// File: rtl/ccd_trim_cal_chk.sv
`timescale 1ns/1ps
module ccd_trim_cal_chk #(
    parameter int DAC_W = 10
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    start,
    input logic                    busy,
    input logic                    done,
    input logic                    err,
    input logic                    await_ack,
    input logic                    phase_gain,
    input logic signed [DAC_W-1:0] ofs_code,
    input logic signed [DAC_W-1:0] gain_code
);
    // R4
    ofs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy && phase_gain |=> $stable(ofs_code));
    // R4
    gain_idle_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !phase_gain |-> gain_code == '0);
    // R7
    flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && err));
    // R2
    ack_busy_chk: assert property (@(posedge clk) disable iff (rst)
        await_ack |-> busy);
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !busy && !start |=> $stable(ofs_code) && $stable(gain_code));
    // R7
    err_end_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> $fell(busy));
    // R5
    done_end_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $fell(busy));
endmodule

bind ccd_trim_cal ccd_trim_cal_chk #(.DAC_W(DAC_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .err(err), .await_ack(await_ack), .phase_gain(phase_gain),
    .ofs_code(ofs_code), .gain_code(gain_code)
);

// File: tb/ccd_trim_cal_tb_top.sv
`timescale 1ns/1ps
module ccd_trim_cal_tb_top;

    typedef struct packed {
        int d0;      // dark level at code 0
        int s0;      // saturated level at code 0
        int slope;   // output codes per DAC step
        int e_ofs;   // expected offset code, 999 = not checked
        int e_gain;
        int e_err;   // 0 ok, 1 limit error, 2 refine-bound error
    } scen_t;

    localparam int NSC = 8;
    localparam scen_t SCN [NSC] = '{
        '{137,   16183, 1, -137,  200, 0},
        '{-45,   16683, 1,   45, -300, 0},
        '{0,     16383, 1,    0,    0, 0},
        '{512,   16895, 1, -512, -512, 0},
        '{-511,  15872, 1,  511,  511, 0},
        '{700,   16383, 1, -512,    0, 1},
        '{-600,  16383, 1,  511,    0, 1},
        '{5,     16383, 2,  999,    0, 2}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, phase_ack = 1'b0;
    logic smp_valid, smp_oor;
    logic [13:0] smp_code;
    logic signed [9:0] ofs_code, gain_code;
    logic busy, done, err, await_ack, phase_gain;

    int checks = 0, failures = 0;
    int d0 = 0, s0 = 16383, slope = 1;
    logic illum = 1'b0;
    logic tog = 1'b0;

    always #2.5 clk = ~clk;

    ccd_trim_cal dut_i (
        .clk(clk), .rst(rst), .start(start), .phase_ack(phase_ack),
        .smp_valid(smp_valid), .smp_code(smp_code), .smp_oor(smp_oor),
        .ofs_code(ofs_code), .gain_code(gain_code), .busy(busy),
        .done(done), .err(err), .await_ack(await_ack),
        .phase_gain(phase_gain)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Converter model; junk words while the strobe is low (R6)
    initial begin
        smp_valid = 1'b0; smp_code = 14'h2AAA; smp_oor = 1'b1;
        forever begin
            int v;
            @(negedge clk);
            smp_valid = 1'b0; smp_code = 14'h2AAA; smp_oor = 1'b1;
            @(negedge clk);
            @(negedge clk);
            if (illum) v = s0 + slope * int'(gain_code) - 1 + int'(tog);
            else       v = d0 + slope * int'(ofs_code) + int'(tog);
            tog = ~tog;
            if (v < 0) begin
                smp_code = 14'd0; smp_oor = 1'b1;
            end else if (v > 16383) begin
                smp_code = 14'h3FFF; smp_oor = 1'b1;
            end else begin
                smp_code = 14'(v); smp_oor = 1'b0;
            end
            smp_valid = 1'b1;
        end
    end

    task automatic pulse_ack();
        @(negedge clk) phase_ack = 1'b1;
        @(negedge clk) phase_ack = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 err", err, 0);
        chk("R1 await_ack", await_ack, 0);
        chk("R1 ofs_code", ofs_code, 0);
        chk("R1 gain_code", gain_code, 0);

        for (int i = 0; i < NSC; i++) begin
            string etag;
            d0 = SCN[i].d0; s0 = SCN[i].s0; slope = SCN[i].slope;
            illum = 1'b0;
            start = 1'b1;
            @(negedge clk) start = 1'b0;
            chk("R2 await_ack", await_ack, 1);
            chk("R2 phase_gain", phase_gain, 0);
            chk("R2 ofs_code", ofs_code, 0);
            chk("R2 gain_code", gain_code, 0);
            if (i > 0) begin
                chk("R9 err cleared", err, 0);
                chk("R9 done cleared", done, 0);
            end
            if (i == 0) begin
                repeat (40) @(negedge clk);
                chk("R2 still waiting", await_ack, 1);
                chk("R2 ofs held", ofs_code, 0);
            end
            pulse_ack();
            if (i == 0) begin
                repeat (5) @(negedge clk);
                start = 1'b1;
                @(negedge clk) start = 1'b0;
                repeat (3) @(negedge clk);
                chk("R9 start ignored busy", busy, 1);
                chk("R9 start ignored ack", await_ack, 0);
                chk("R9 start ignored phase", phase_gain, 0);
            end
            while (busy && !await_ack) @(negedge clk);
            if (SCN[i].e_err != 0) begin
                etag = (SCN[i].e_err == 2) ? "R8" : "R7";
                chk({etag, " err"}, err, 1);
                chk({etag, " done"}, done, 0);
                chk({etag, " busy"}, busy, 0);
                chk({etag, " gain untouched"}, gain_code, 0);
                if (SCN[i].e_ofs != 999)
                    chk({etag, " ofs at limit"}, ofs_code, SCN[i].e_ofs);
            end else begin
                chk("R4 gain phase request", await_ack && phase_gain, 1);
                chk("R3 ofs result", ofs_code, SCN[i].e_ofs);
                chk("R4 gain before phase", gain_code, 0);
                illum = 1'b1;
                pulse_ack();
                while (busy) @(negedge clk);
                chk("R5 done", done, 1);
                chk("R5 err", err, 0);
                chk("R5 gain result", gain_code, SCN[i].e_gain);
                chk("R4 ofs kept", ofs_code, SCN[i].e_ofs);
                chk("R6 window result dark check", d0 + int'(ofs_code), 0);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule